// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin General-Purpose I/O Port

This block is a memory-mapped general-purpose I/O port for 32 pins. It sits on a simple register bus with an address, a write strobe, write data and read data. Writes take effect on the clock edge where the strobe is high. Reads are combinational from the current address.

Software drives the output pins through a data register and an output-enable (direction) register. For single pins it can use two atomic registers, one that raises bits and one that lowers them, so no read-modify-write is needed. Incoming pin values pass through a two-stage synchronizer and can be read back.

Every pin also has an interrupt detector. Three configuration bits choose one of five trigger modes: rising edge, falling edge, either edge, high level or low level. A detected event sets a sticky per-pin status bit, but only while that pin is enabled. A per-pin mask keeps a pending bit off the single combined interrupt line. Status bits are cleared by writing ones to a clear register. Software scans the status word from bit 0 upward to find the pending pins.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every storage register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is low.
- R2: A write to offset 0x00 loads the output data word, which appears on `pin_out` and reads back at 0x00. A write to offset 0x08 loads the direction word: a 1 bit drives the matching `pin_oe` bit high (output) and a 0 bit makes the pin an input.
- R3: Writing to offset 0x10 raises every output bit written as 1. Writing to offset 0x14 lowers every output bit written as 1. In both registers, bits written as 0 keep their value. Reads of 0x10, 0x14 and 0x30 return 0.
- R4: Offset 0x04 returns `pin_in` through a two-flop synchronizer. A pin change is readable after the second rising clock edge.
- R5: The three mode registers are level-select (offset 0x34), polarity (offset 0x3C) and either-edge (offset 0x38). With level-select 0 and either-edge 0, a polarity bit of 0 makes a 0-to-1 input transition set the status bit, and a polarity bit of 1 makes a 1-to-0 transition set it. The status bit is set on the third clock edge after the pin change.
- R6: With level-select 0 and either-edge 1, both transitions set the status bit, whatever the polarity bit holds.
- R7: With level-select 1, a polarity bit of 0 sets the status bit while the synchronized input is high, and a polarity bit of 1 sets it while the input is low. Clearing a status bit has no lasting effect while its level is still active. A status bit that was set stays 1 after the level goes away.
- R8: Status (offset 0x24) is sticky. Writing 1s to offset 0x30 clears the matching status bits, and writing all ones clears every bit that has no active event. A status bit falls only through such a write.
- R9: A status bit can be set only while its enable bit (offset 0x20) is 1.
- R10: `irq` is high exactly when some status bit is 1 while its mask bit (offset 0x2C) is 0. A mask bit does not stop its status bit from being set.
- R11: Offsets 0x18 and 0x1C are plain read/write storage and have no effect on pins or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The interrupt detectors are exercised on five pins at once, each set to a different trigger mode. Each is driven through a common rise and then a common fall, so one status word shows which modes respond to which transition. Clears are issued while some levels are still active, so level persistence is distinguished from sticky edge status. Enable and mask are toggled separately against the same pin event, which separates gating of the status bit from gating of the combined line. Atomic set and clear use overlapping and disjoint patterns, so that untouched bits can be seen keeping their value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PORT_PINS = 32;
    localparam int unsigned OFS_W     = 8;

    typedef enum logic [OFS_W-1:0] {
        OFS_DOUT  = 8'h00,
        OFS_DIN   = 8'h04,
        OFS_DIR   = 8'h08,
        OFS_RAISE = 8'h10,
        OFS_LOWER = 8'h14,
        OFS_PULA  = 8'h18,
        OFS_PULB  = 8'h1C,
        OFS_IEN   = 8'h20,
        OFS_IST   = 8'h24,
        OFS_IMSK  = 8'h2C,
        OFS_IACK  = 8'h30,
        OFS_ILVL  = 8'h34,
        OFS_IANY  = 8'h38,
        OFS_IPOL  = 8'h3C
    } reg_ofs_e;

    typedef enum logic [2:0] {
        TRIG_RISE,
        TRIG_FALL,
        TRIG_ANY,
        TRIG_HIGH,
        TRIG_LOW
    } trig_e;

    typedef struct packed {
        logic is_level;
        logic invert;
        logic any_edge;
    } trig_cfg_t;

    function automatic trig_e decode_trig(trig_cfg_t c);
        if (c.is_level)
            return c.invert ? TRIG_LOW : TRIG_HIGH;
        else if (c.any_edge)
            return TRIG_ANY;
        else
            return c.invert ? TRIG_FALL : TRIG_RISE;
    endfunction

    function automatic logic trig_hit(trig_e m, logic cur, logic prev);
        case (m)
            TRIG_RISE: return cur & ~prev;
            TRIG_FALL: return ~cur & prev;
            TRIG_ANY:  return cur ^ prev;
            TRIG_HIGH: return cur;
            TRIG_LOW:  return ~cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN   = PORT_PINS,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] raw_in,
    output logic [NPIN-1:0] cur_o,
    output logic [NPIN-1:0] prev_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [NPIN-1:0] stg [STAGES];
    logic [NPIN-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stg[LAST];
    end

    assign cur_o  = stg[LAST];
    assign prev_o = prev_q;

    assert_prev_follows_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev_o == $past(cur_o)))
        else $error("previous-sample register lost track");

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = PORT_PINS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OFS_W-1:0]      addr,
    input  logic                  we,
    input  logic [NPIN-1:0]       wdata,
    output logic [NPIN-1:0]       rdata,
    input  logic [NPIN-1:0]       din_sync,
    input  logic [NPIN-1:0]       status,
    output logic [NPIN-1:0]       dout_q,
    output logic [NPIN-1:0]       dir_q,
    output logic [NPIN-1:0]       ien_q,
    output logic [NPIN-1:0]       imsk_q,
    output logic [NPIN-1:0]       ack_o,
    output trig_cfg_t [NPIN-1:0]  cfg_o
);
    logic [NPIN-1:0] pula_q, pulb_q, ilvl_q, iany_q, ipol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
            pula_q <= '0;
            pulb_q <= '0;
            ien_q  <= '0;
            imsk_q <= '0;
            ilvl_q <= '0;
            iany_q <= '0;
            ipol_q <= '0;
        end else if (we) begin
            case (addr)
                OFS_DOUT:  dout_q <= wdata;
                OFS_RAISE: dout_q <= dout_q | wdata;
                OFS_LOWER: dout_q <= dout_q & ~wdata;
                OFS_DIR:   dir_q  <= wdata;
                OFS_PULA:  pula_q <= wdata;
                OFS_PULB:  pulb_q <= wdata;
                OFS_IEN:   ien_q  <= wdata;
                OFS_IMSK:  imsk_q <= wdata;
                OFS_ILVL:  ilvl_q <= wdata;
                OFS_IANY:  iany_q <= wdata;
                OFS_IPOL:  ipol_q <= wdata;
                default: ;
            endcase
        end
    end

    assign ack_o = (we && addr == OFS_IACK) ? wdata : '0;

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_cfg
            assign cfg_o[i] = '{is_level: ilvl_q[i], invert: ipol_q[i], any_edge: iany_q[i]};
        end
    endgenerate

    always_comb begin
        case (addr)
            OFS_DOUT: rdata = dout_q;
            OFS_DIN:  rdata = din_sync;
            OFS_DIR:  rdata = dir_q;
            OFS_PULA: rdata = pula_q;
            OFS_PULB: rdata = pulb_q;
            OFS_IEN:  rdata = ien_q;
            OFS_IST:  rdata = status;
            OFS_IMSK: rdata = imsk_q;
            OFS_ILVL: rdata = ilvl_q;
            OFS_IANY: rdata = iany_q;
            OFS_IPOL: rdata = ipol_q;
            default:  rdata = '0;
        endcase
    end

    assert_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_RAISE) |=>
            (((dout_q & $past(wdata)) == $past(wdata)) &&
             ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))))
        else $error("raise register misbehaved");

    assert_lower_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_LOWER) |=>
            (((dout_q & $past(wdata)) == '0) &&
             ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))))
        else $error("lower register misbehaved");

    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(we && (addr == OFS_DOUT || addr == OFS_RAISE || addr == OFS_LOWER)) |=> $stable(dout_q))
        else $error("output data changed without a write");

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = PORT_PINS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  trig_cfg_t [NPIN-1:0]  cfg,
    input  logic [NPIN-1:0]       en,
    input  logic [NPIN-1:0]       ack,
    input  logic [NPIN-1:0]       cur,
    input  logic [NPIN-1:0]       prev,
    output logic [NPIN-1:0]       status_o
);
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] status_q;

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_pin
            trig_e mode;
            assign mode   = decode_trig(cfg[i]);
            assign hit[i] = en[i] & trig_hit(mode, cur[i], prev[i]);

            assert_gated_R9: assert property (@(posedge clk) disable iff (rst)
                $rose(status_q[i]) |-> $past(en[i]))
                else $error("status set while disabled");

            assert_fall_by_ack_R8: assert property (@(posedge clk) disable iff (rst)
                $fell(status_q[i]) |-> $past(ack[i]))
                else $error("status fell without a clear write");

            assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (cfg[i].is_level && en[i] && (cur[i] != cfg[i].invert)) |=> status_q[i])
                else $error("active level did not hold status");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~ack) | hit;
    end

    assign status_o = status_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN        = PORT_PINS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [NPIN-1:0]  bus_wdata,
    output logic [NPIN-1:0]  bus_rdata,
    input  logic [NPIN-1:0]  pin_in,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe,
    output logic             irq
);
    logic [NPIN-1:0] cur, prev, status, ien, imsk, ack;
    trig_cfg_t [NPIN-1:0] cfg;

    gpio_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_in(pin_in), .cur_o(cur), .prev_o(prev)
    );

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .rdata(bus_rdata), .din_sync(cur), .status(status),
        .dout_q(pin_out), .dir_q(pin_oe), .ien_q(ien), .imsk_q(imsk),
        .ack_o(ack), .cfg_o(cfg)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk(clk), .rst(rst), .cfg(cfg), .en(ien), .ack(ack),
        .cur(cur), .prev(prev), .status_o(status)
    );

    assign irq = |(status & ~imsk);

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0))
        else $error("interrupt without pending status");

    assert_full_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (&imsk) |-> !irq)
        else $error("interrupt despite full mask");

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_irq_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: one scoreboard item per falling edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0: act = bus_rdata;
                1: act = pin_out;
                2: act = {31'b0, irq};
                default: act = pin_oe;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step();
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        step();
        bus_we = 1'b0; bus_addr = a;
        sb_q.push_back('{0, e, tag});
    endtask

    task automatic exp_port(input int sel, input logic [31:0] e, input string tag);
        step();
        sb_q.push_back('{sel, e, tag});
    endtask

    task automatic settle();
        repeat (4) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        exp_rd(8'h00, 32'h0, "R1 dout");
        exp_rd(8'h08, 32'h0, "R1 dir");
        exp_rd(8'h20, 32'h0, "R1 ien");
        exp_rd(8'h24, 32'h0, "R1 status");
        exp_port(2, 32'h0, "R1 irq");
        exp_port(1, 32'h0, "R1 pin_out");

        // R2 data out and direction
        wr(8'h00, 32'hA5A5_0000);
        exp_rd(8'h00, 32'hA5A5_0000, "R2 dout readback");
        exp_port(1, 32'hA5A5_0000, "R2 pin_out");
        wr(8'h08, 32'hFFFF_0000);
        exp_port(3, 32'hFFFF_0000, "R2 pin_oe");

        // R3 atomic raise and lower
        wr(8'h10, 32'h0000_00FF);
        exp_port(1, 32'hA5A5_00FF, "R3 raise");
        wr(8'h14, 32'hA000_0001);
        exp_port(1, 32'h05A5_00FE, "R3 lower");
        wr(8'h10, 32'h0);
        exp_port(1, 32'h05A5_00FE, "R3 raise zero no effect");
        exp_rd(8'h10, 32'h0, "R3 raise reads 0");
        exp_rd(8'h14, 32'h0, "R3 lower reads 0");
        exp_rd(8'h30, 32'h0, "R3 ack reads 0");

        // R4 synchronized input
        step(); pins = 32'h1234_5678;
        step();
        exp_rd(8'h04, 32'h1234_5678, "R4 input after two edges");

        // R11 pull storage
        wr(8'h18, 32'h0000_0055);
        wr(8'h1C, 32'hAA00_0000);
        exp_rd(8'h18, 32'h0000_0055, "R11 pull A");
        exp_rd(8'h1C, 32'hAA00_0000, "R11 pull B");
        exp_port(1, 32'h05A5_00FE, "R11 pin_out untouched");
        exp_rd(8'h24, 32'h0, "R11 no status");

        // interrupt configuration: pin0 rise, pin1 fall, pin2 any, pin3 high, pin4 low
        step(); pins = 32'h0;
        settle();
        wr(8'h34, 32'h18);
        wr(8'h3C, 32'h12);
        wr(8'h38, 32'h04);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h20, 32'h1F);
        settle();
        wr(8'h30, 32'hFFFF_FFFF);
        exp_rd(8'h24, 32'h10, "R7 low level persists after clear");
        exp_port(2, 32'h1, "R10 irq on pending");

        step(); pins = 32'h1F;
        settle();
        exp_rd(8'h24, 32'h1D, "R5 R6 R7 rise pattern");
        wr(8'h30, 32'h1F);
        exp_rd(8'h24, 32'h08, "R8 clear keeps active high level");

        step(); pins = 32'h0;
        settle();
        exp_rd(8'h24, 32'h1E, "R5 R6 R7 fall pattern");
        wr(8'h30, 32'h0F);
        exp_rd(8'h24, 32'h10, "R8 partial clear");

        // R10 mask
        wr(8'h2C, 32'h10);
        exp_port(2, 32'h0, "R10 masked irq low");
        exp_rd(8'h24, 32'h10, "R10 status kept under mask");
        wr(8'h2C, 32'h0);
        exp_port(2, 32'h1, "R10 unmasked irq high");

        // R9 enable gating
        wr(8'h20, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        step(); pins = 32'h1;
        settle();
        exp_rd(8'h24, 32'h0, "R9 disabled no status");
        exp_port(2, 32'h0, "R9 irq low");
        wr(8'h20, 32'h01);
        wr(8'h2C, 32'h01);
        step(); pins = 32'h0;
        settle();
        step(); pins = 32'h1;
        settle();
        exp_rd(8'h24, 32'h01, "R9 R10 masked pin still sets status");
        exp_port(2, 32'h0, "R10 masked pin keeps irq low");

        step(); step(); step();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule